// File: doc/BRIEF.md
# Multiprocessor Interrupt Register Bank

This block is the register side of an interrupt controller that serves up to sixteen processors over APB. It holds the per-line level selection, the shared pending set, the per-line broadcast choice, and, for every processor, an interrupt mask, a private force set and a read-only extended identifier. Incoming interrupt pulses are captured here. Each line's broadcast bit decides where a pulse goes. A line without broadcast goes to the shared pending set, which any single acknowledge retires. A broadcast line goes to the force set of every processor, and each processor must retire its own copy.

The block also drives processor start control. After reset only processor 0 is released. Any other processor is released, and given a one-cycle restart pulse, when software writes a 1 to its bit of the status register. Reads of that status register return the live halted flags reported by the processors. Priority selection and cascade decoding sit in neighbouring blocks. They take the level, pending, mask and force vectors from this block's outputs and return the extended identifiers for read-back.

Top module: `irqbank_apb`

## Requirements
- R1: Registers decode on byte offsets: 0x00 level, 0x14 broadcast, 0x40+4n mask of processor n, 0x80+4n force of processor n. These registers read back the written value masked to bits 15..1. Bits 31..16 and bit 0 always read 0.
- R2: A write to 0x04 replaces the pending set. A write to the clear register at 0x0C clears the pending bits at 1 positions and leaves the bits at 0 positions. The clear register reads 0.
- R3: A pulse on irq_in bit L (L in 1..15) whose broadcast bit is 0 sets pending bit L on the next clock edge and changes no force bit.
- R4: A pulse on a line whose broadcast bit is 1 sets bit L in the force register of every processor and leaves pending unchanged.
- R5: An acknowledge from processor m (ack_valid bit m, line number in ack_line[4m+3:4m]) clears pending bit L and processor m's force bit L. It leaves the other processors' force bits unchanged.
- R6: An acknowledge clears its line even when that line is masked (mask bit 0) for the acknowledging processor.
- R7: When a pulse and an acknowledge hit the same line in the same cycle, the bit ends up set.
- R8: Line 0 is reserved: a pulse on irq_in bit 0 and a write to bit 0 of any line register have no effect.
- R9: With one processor, the broadcast register reads 0 and ignores writes, so all pulses go to pending. Offset 0x08 is then an alias of processor 0's force register. With more than one processor, 0x08 reads 0.
- R10: The status register at 0x10 returns cpu_halted in bits NCPU-1..0 (1 = halted) and 0 above.
- R11: After reset cpu_hold is 1 for every processor except processor 0. Writing 1 to status bit n clears cpu_hold bit n and raises cpu_restart bit n for exactly one cycle. Bits written 0 have no effect.
- R12: Offset 0xC0+4n returns processor n's extended identifier input in bits 4..0. Writes to it are ignored.
- R13: Unmapped offsets, and per-processor offsets with n at or above the processor count, read 0. pready is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 8 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| irq_in | input | 16 | Interrupt pulses, one per line |
| ack_valid | input | NCPU | Acknowledge strobe per processor |
| ack_line | input | 4*NCPU | Acknowledged line number per processor |
| cpu_halted | input | NCPU | Halted flag per processor |
| xid_in | input | 5*NCPU | Extended identifier per processor, from the cascade logic |
| level_o | output | 16 | Level register to priority logic |
| pend_o | output | 16 | Shared pending set |
| mask_o | output | 16*NCPU | Mask register per processor |
| force_o | output | 16*NCPU | Force set per processor |
| cpu_hold | output | NCPU | Processor held halted |
| cpu_restart | output | NCPU | One-cycle restart pulse per processor |

## Verification
A pulse routed to the wrong set shows on pend_o or force_o one clock edge after the pulse. The same holds for an acknowledge that retires another processor's copy, or that fails to retire a masked line: the vectors are registered and the bench reads them on the following falling edge. Decode faults show up on the very next APB read, as a value returned at the wrong offset or a nonzero unmapped read. Start-control faults show up in cpu_hold and cpu_restart in the cycle after the status write completes.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
    localparam int LINES  = 16;
    localparam int LINE_W = 4;
    localparam int ADDR_W = 8;
    localparam int XID_W  = 5;
    localparam logic [LINES-1:0] LINE_USE = 16'hFFFE;

    typedef enum logic [3:0] {
        REG_NONE, REG_LEVEL, REG_PEND, REG_FORCE1, REG_CLEAR,
        REG_STAT, REG_BCAST, REG_MASK, REG_FORCE, REG_XID
    } reg_e;

    typedef struct packed {
        reg_e              kind;
        logic [LINE_W-1:0] cpu;
    } dec_t;

    function automatic logic [LINES-1:0] line_bit(input logic [LINE_W-1:0] l);
        return LINE_USE & (LINES'(1) << l);
    endfunction
endpackage

// File: rtl/irqbank_decode.sv
module irqbank_decode
    import irqbank_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic [ADDR_W-1:0] paddr,
    output dec_t              dec
);
    logic [LINE_W-1:0] idx;
    logic              idx_ok;

    assign idx    = paddr[5:2];
    assign idx_ok = int'(idx) < NCPU;

    always_comb begin
        dec.cpu  = idx;
        dec.kind = REG_NONE;
        unique case (paddr[7:6])
            2'b00: begin
                case (idx)
                    4'd0: dec.kind = REG_LEVEL;
                    4'd1: dec.kind = REG_PEND;
                    4'd2: dec.kind = (NCPU == 1) ? REG_FORCE1 : REG_NONE;
                    4'd3: dec.kind = REG_CLEAR;
                    4'd4: dec.kind = REG_STAT;
                    4'd5: dec.kind = REG_BCAST;
                    default: dec.kind = REG_NONE;
                endcase
            end
            2'b01: dec.kind = idx_ok ? REG_MASK  : REG_NONE;
            2'b10: dec.kind = idx_ok ? REG_FORCE : REG_NONE;
            2'b11: dec.kind = idx_ok ? REG_XID   : REG_NONE;
            default: dec.kind = REG_NONE;
        endcase
    end

    logic unused_dec;
    assign unused_dec = ^paddr[1:0];
endmodule

// File: rtl/irqbank_shared.sv
module irqbank_shared
    import irqbank_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_level,
    input  logic             wr_pend,
    input  logic             wr_clear,
    input  logic             wr_bcast,
    input  logic [LINES-1:0] wdata,
    input  logic [LINES-1:0] irq_in,
    input  logic [LINES-1:0] ack_clr,
    output logic [LINES-1:0] level_q,
    output logic [LINES-1:0] pend_q,
    output logic [LINES-1:0] bcast_q,
    output logic [LINES-1:0] bset
);
    logic [LINES-1:0] pset;
    logic [LINES-1:0] pend_base;
    logic [LINES-1:0] pend_clr;
    logic [LINES-1:0] pend_next;

    generate
        if (NCPU > 1) begin : g_bcast
            always_ff @(posedge clk) begin
                if (rst)           bcast_q <= '0;
                else if (wr_bcast) bcast_q <= wdata & LINE_USE;
            end
        end else begin : g_nobcast
            assign bcast_q = '0;
        end
    endgenerate

    assign pset = irq_in & LINE_USE & ~bcast_q;
    assign bset = irq_in & LINE_USE & bcast_q;

    always_comb begin
        pend_base = wr_pend ? (wdata & LINE_USE) : pend_q;
        pend_clr  = ack_clr | (wr_clear ? wdata : '0);
        pend_next = (pend_base & ~pend_clr) | pset;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            pend_q  <= '0;
        end else begin
            if (wr_level) level_q <= wdata & LINE_USE;
            pend_q <= pend_next & LINE_USE;
        end
    end

    // R3
    pend_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (|pset) |=> ((pend_q & $past(pset)) == $past(pset)));

    // R5
    pend_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (|(ack_clr & ~pset)) |=> ((pend_q & $past(ack_clr & ~pset)) == '0));

    // R4
    bcast_route_chk: assert property (@(posedge clk) disable iff (rst)
        ((|bset) && !wr_pend) |=> ((pend_q & $past(bset & ~pend_q)) == '0));
endmodule

// File: rtl/irqbank_cpu.sv
module irqbank_cpu
    import irqbank_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_mask,
    input  logic              wr_force,
    input  logic [LINES-1:0]  wdata,
    input  logic [LINES-1:0]  bset,
    input  logic              ack_valid,
    input  logic [LINE_W-1:0] ack_line,
    input  logic              start_req,
    output logic [LINES-1:0]  mask_q,
    output logic [LINES-1:0]  force_q,
    output logic              hold_q,
    output logic              restart_q
);
    logic [LINES-1:0] own_ack;
    logic [LINES-1:0] force_base;

    assign own_ack    = ack_valid ? line_bit(ack_line) : '0;
    assign force_base = wr_force ? (wdata & LINE_USE) : force_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q    <= '0;
            force_q   <= '0;
            hold_q    <= (IDX != 0);
            restart_q <= 1'b0;
        end else begin
            if (wr_mask) mask_q <= wdata & LINE_USE;
            force_q   <= ((force_base & ~own_ack) | bset) & LINE_USE;
            restart_q <= start_req;
            if (start_req) hold_q <= 1'b0;
        end
    end

    // R4
    force_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (|bset) |=> ((force_q & $past(bset)) == $past(bset)));

    // R5
    force_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (|(own_ack & ~bset)) |=> ((force_q & $past(own_ack & ~bset)) == '0));

    // R11
    restart_hold_chk: assert property (@(posedge clk) disable iff (rst)
        restart_q |-> !hold_q);
endmodule

// File: rtl/irqbank_apb.sv
module irqbank_apb
    import irqbank_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     psel,
    input  logic                     penable,
    input  logic                     pwrite,
    input  logic [7:0]               paddr,
    input  logic [31:0]              pwdata,
    output logic [31:0]              prdata,
    output logic                     pready,
    input  logic [15:0]              irq_in,
    input  logic [NCPU-1:0]          ack_valid,
    input  logic [4*NCPU-1:0]        ack_line,
    input  logic [NCPU-1:0]          cpu_halted,
    input  logic [5*NCPU-1:0]        xid_in,
    output logic [15:0]              level_o,
    output logic [15:0]              pend_o,
    output logic [16*NCPU-1:0]       mask_o,
    output logic [16*NCPU-1:0]       force_o,
    output logic [NCPU-1:0]          cpu_hold,
    output logic [NCPU-1:0]          cpu_restart
);
    dec_t             dec;
    logic             wr;
    logic [LINES-1:0] wdata;
    logic [LINES-1:0] ack_clr;
    logic [LINES-1:0] bcast_q;
    logic [LINES-1:0] bset;
    logic [LINES-1:0] mask_arr  [NCPU];
    logic [LINES-1:0] force_arr [NCPU];

    assign pready = 1'b1;
    assign wr     = psel & penable & pwrite;
    assign wdata  = pwdata[LINES-1:0];

    irqbank_decode #(.NCPU(NCPU)) u_dec (
        .paddr (paddr),
        .dec   (dec)
    );

    always_comb begin
        ack_clr = '0;
        for (int n = 0; n < NCPU; n++) begin
            if (ack_valid[n]) ack_clr |= line_bit(ack_line[n*LINE_W +: LINE_W]);
        end
    end

    irqbank_shared #(.NCPU(NCPU)) u_shared (
        .clk      (clk),
        .rst      (rst),
        .wr_level (wr && dec.kind == REG_LEVEL),
        .wr_pend  (wr && dec.kind == REG_PEND),
        .wr_clear (wr && dec.kind == REG_CLEAR),
        .wr_bcast (wr && dec.kind == REG_BCAST),
        .wdata    (wdata),
        .irq_in   (irq_in),
        .ack_clr  (ack_clr),
        .level_q  (level_o),
        .pend_q   (pend_o),
        .bcast_q  (bcast_q),
        .bset     (bset)
    );

    generate
        for (genvar n = 0; n < NCPU; n++) begin : g_cpu
            logic sel_n;
            assign sel_n = int'(dec.cpu) == n;

            irqbank_cpu #(.IDX(n)) u_cpu (
                .clk       (clk),
                .rst       (rst),
                .wr_mask   (wr && dec.kind == REG_MASK && sel_n),
                .wr_force  (wr && ((dec.kind == REG_FORCE && sel_n) ||
                                   (dec.kind == REG_FORCE1 && n == 0))),
                .wdata     (wdata),
                .bset      (bset),
                .ack_valid (ack_valid[n]),
                .ack_line  (ack_line[n*LINE_W +: LINE_W]),
                .start_req (wr && dec.kind == REG_STAT && pwdata[n]),
                .mask_q    (mask_arr[n]),
                .force_q   (force_arr[n]),
                .hold_q    (cpu_hold[n]),
                .restart_q (cpu_restart[n])
            );

            assign mask_o[n*LINES +: LINES]  = mask_arr[n];
            assign force_o[n*LINES +: LINES] = force_arr[n];
        end
    endgenerate

    always_comb begin
        prdata = '0;
        case (dec.kind)
            REG_LEVEL:  prdata[LINES-1:0] = level_o;
            REG_PEND:   prdata[LINES-1:0] = pend_o;
            REG_BCAST:  prdata[LINES-1:0] = bcast_q;
            REG_FORCE1: prdata[LINES-1:0] = force_arr[0];
            REG_STAT:   prdata[NCPU-1:0]  = cpu_halted;
            REG_MASK, REG_FORCE, REG_XID: begin
                for (int n = 0; n < NCPU; n++) begin
                    if (int'(dec.cpu) == n) begin
                        if (dec.kind == REG_MASK)       prdata[LINES-1:0] = mask_arr[n];
                        else if (dec.kind == REG_FORCE) prdata[LINES-1:0] = force_arr[n];
                        else                            prdata[XID_W-1:0] = xid_in[n*XID_W +: XID_W];
                    end
                end
            end
            default: prdata = '0;
        endcase
    end

    logic unused_top;
    assign unused_top = ^pwdata[31:16];

    // R13
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && dec.kind == REG_NONE) |-> (prdata == '0));
endmodule

// File: tb/sim_irqbank_apb.sv
module sim_irqbank_apb;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    // four-processor instance
    logic psel = 0, penable = 0, pwrite = 0;
    logic [7:0]  paddr = 0;
    logic [31:0] pwdata = 0, prdata;
    logic pready;
    logic [15:0] irq_in = 0;
    logic [NC-1:0] ack_valid = 0;
    logic [4*NC-1:0] ack_line = 0;
    logic [NC-1:0] cpu_halted = 0;
    logic [5*NC-1:0] xid_in = 0;
    logic [15:0] level_o, pend_o;
    logic [16*NC-1:0] mask_o, force_o;
    logic [NC-1:0] cpu_hold, cpu_restart;

    irqbank_apb #(.NCPU(NC)) u0 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .irq_in(irq_in), .ack_valid(ack_valid), .ack_line(ack_line),
        .cpu_halted(cpu_halted), .xid_in(xid_in), .level_o(level_o),
        .pend_o(pend_o), .mask_o(mask_o), .force_o(force_o),
        .cpu_hold(cpu_hold), .cpu_restart(cpu_restart)
    );

    // single-processor instance
    logic s_psel = 0, s_penable = 0, s_pwrite = 0;
    logic [7:0]  s_paddr = 0;
    logic [31:0] s_pwdata = 0, s_prdata;
    logic s_pready;
    logic [15:0] s_irq = 0;
    logic [15:0] s_level, s_pend, s_mask, s_force;
    logic s_hold, s_restart;

    irqbank_apb #(.NCPU(1)) u1 (
        .clk(clk), .rst(rst), .psel(s_psel), .penable(s_penable), .pwrite(s_pwrite),
        .paddr(s_paddr), .pwdata(s_pwdata), .prdata(s_prdata), .pready(s_pready),
        .irq_in(s_irq), .ack_valid(1'b0), .ack_line(4'd0),
        .cpu_halted(1'b0), .xid_in(5'd0), .level_o(s_level),
        .pend_o(s_pend), .mask_o(s_mask), .force_o(s_force),
        .cpu_hold(s_hold), .cpu_restart(s_restart)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input bit single, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        if (single) begin s_psel = 1; s_pwrite = 1; s_paddr = a; s_pwdata = d; end
        else        begin psel = 1;   pwrite = 1;   paddr = a;   pwdata = d;   end
        @(negedge clk);
        if (single) s_penable = 1; else penable = 1;
        @(negedge clk);
        s_psel = 0; s_penable = 0; s_pwrite = 0;
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input bit single, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        if (single) begin s_psel = 1; s_pwrite = 0; s_paddr = a; end
        else        begin psel = 1;   pwrite = 0;   paddr = a;   end
        @(negedge clk);
        if (single) s_penable = 1; else penable = 1;
        #1 d = single ? s_prdata : prdata;
        @(negedge clk);
        s_psel = 0; s_penable = 0; psel = 0; penable = 0;
    endtask

    task automatic pulse(input logic [15:0] lines);
        @(negedge clk); irq_in = lines;
        @(negedge clk); irq_in = 0;
    endtask

    task automatic ack(input int cpu, input logic [3:0] line);
        @(negedge clk); ack_valid[cpu] = 1'b1; ack_line[cpu*4 +: 4] = line;
        @(negedge clk); ack_valid = '0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11 reset hold", 64'(cpu_hold), 64'(4'b1110));
        chk("R11 reset restart", 64'(cpu_restart), 64'h0);
        chk("reset pending", 64'(pend_o), 64'h0);
        chk("reset force", force_o, 64'h0);
    endtask

    task automatic t_regs_r1();
        logic [31:0] d;
        wr(0, 8'h00, 32'hFFFF_FFFF); rd(0, 8'h00, d); chk("R1 level", 64'(d), 64'h0000_FFFE);
        wr(0, 8'h14, 32'h0000_00F0); rd(0, 8'h14, d); chk("R1 bcast", 64'(d), 64'h00F0);
        wr(0, 8'h48, 32'h0000_1234); rd(0, 8'h48, d); chk("R1 mask2", 64'(d), 64'h1234);
        wr(0, 8'h8C, 32'h0000_0006); rd(0, 8'h8C, d); chk("R1 force3", 64'(d), 64'h0006);
        wr(0, 8'h8C, 32'h0);
    endtask

    task automatic t_pend_r2();
        logic [31:0] d;
        wr(0, 8'h04, 32'h00F0); rd(0, 8'h04, d); chk("R2 pend write", 64'(d), 64'h00F0);
        wr(0, 8'h0C, 32'h0030); rd(0, 8'h04, d); chk("R2 clear", 64'(d), 64'h00C0);
        rd(0, 8'h0C, d); chk("R2 clear reads 0", 64'(d), 64'h0);
    endtask

    task automatic t_route_r3_r4();
        pulse(16'h0004);
        chk("R3 pending set", 64'(pend_o), 64'h00C4);
        chk("R3 no force", force_o, 64'h0);
        pulse(16'h0020);
        chk("R4 force all", force_o, 64'h0020_0020_0020_0020);
        chk("R4 pending same", 64'(pend_o), 64'h00C4);
    endtask

    task automatic t_ack_r5_r6();
        logic [31:0] d;
        ack(1, 4'd5);
        chk("R5 own copy", force_o, 64'h0020_0020_0000_0020);
        ack(0, 4'd2);
        chk("R5 shared ack", 64'(pend_o), 64'h00C0);
        rd(0, 8'h40, d); chk("R6 mask0 zero", 64'(d), 64'h0);
        ack(0, 4'd7);
        chk("R6 masked ack", 64'(pend_o), 64'h0040);
    endtask

    task automatic t_race_r7();
        @(negedge clk); irq_in = 16'h0008; ack_valid[2] = 1'b1; ack_line[8 +: 4] = 4'd3;
        @(negedge clk); irq_in = 0; ack_valid = '0;
        chk("R7 set wins", 64'(pend_o), 64'h0048);
    endtask

    task automatic t_line0_r8();
        logic [31:0] d;
        pulse(16'h0001);
        chk("R8 pulse line0", 64'(pend_o), 64'h0048);
        wr(0, 8'h04, 32'hFFFF); rd(0, 8'h04, d);
        chk("R8 write bit0", 64'(d), 64'hFFFE);
    endtask

    task automatic t_single_r9();
        logic [31:0] d;
        wr(1, 8'h14, 32'hFFFF); rd(1, 8'h14, d); chk("R9 bcast off", 64'(d), 64'h0);
        @(negedge clk); s_irq = 16'h0010;
        @(negedge clk); s_irq = 0;
        chk("R9 to pending", 64'(s_pend), 64'h0010);
        chk("R9 no force", 64'(s_force), 64'h0);
        wr(1, 8'h08, 32'h0006); rd(1, 8'h80, d); chk("R9 alias", 64'(d), 64'h0006);
        rd(0, 8'h08, d); chk("R9 multi 0x08", 64'(d), 64'h0);
    endtask

    task automatic t_status_r10_r11();
        logic [31:0] d;
        cpu_halted = 4'b1010;
        rd(0, 8'h10, d); chk("R10 status", 64'(d), 64'h0000_000A);
        @(negedge clk); psel = 1; pwrite = 1; paddr = 8'h10; pwdata = 32'h4;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
        chk("R11 restart pulse", 64'(cpu_restart), 64'(4'b0100));
        chk("R11 hold cleared", 64'(cpu_hold), 64'(4'b1010));
        @(negedge clk);
        chk("R11 pulse one cycle", 64'(cpu_restart), 64'h0);
    endtask

    task automatic t_xid_r12();
        logic [31:0] d;
        xid_in[9:5] = 5'd19;
        rd(0, 8'hC4, d); chk("R12 xid read", 64'(d), 64'd19);
        wr(0, 8'hC4, 32'h0); rd(0, 8'hC4, d); chk("R12 xid ro", 64'(d), 64'd19);
    endtask

    task automatic t_unmapped_r13();
        logic [31:0] d;
        rd(0, 8'h18, d); chk("R13 hole", 64'(d), 64'h0);
        rd(0, 8'h50, d); chk("R13 cpu4", 64'(d), 64'h0);
        chk("R13 pready", 64'(pready), 64'h1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_regs_r1();
        t_pend_r2();
        t_route_r3_r4();
        t_ack_r5_r6();
        t_race_r7();
        t_line0_r8();
        t_single_r9();
        t_status_r10_r11();
        t_xid_r12();
        t_unmapped_r13();
        done = 1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule